// File: doc/BRIEF.md
# RMII Transmit Dibit Serializer

This block sits between a MAC-side byte stream and the transmit pins of a reduced media-independent interface. Every signal runs on the continuous 50 MHz reference clock. When a source offers a byte while the line is quiet, the block opens a frame. It first sends seven 0x55 preamble bytes and one 0xD5 delimiter byte. It then pulls the frame bytes from the source one at a time and drives each byte onto the two data pins as four two-bit groups. The source must already have appended the frame check sequence to its bytes.

The upstream handshake is a byte, a valid flag, a last flag and a ready strobe. Ready rises for one clock in every four. A byte is taken at the clock edge where ready and valid are both high, so the next byte follows the current one with no idle slot. After the last byte, or after the source fails to offer a byte when one is due, the drive-enable output falls. The line then stays quiet for the interframe gap. A missed byte also raises a one-clock underrun pulse.

Top module: `rmii_tx_serializer`

## Requirements
- R1: While reset is high, and on the first clock after it, dib_en, s_ready and starved are 0 and both data pins are 0.
- R2: Whenever dib_en is 0, dib_lo and dib_hi are both 0.
- R3: One clock after an edge that finds s_valid high while the line is idle and the gap has elapsed, dib_en rises. The pins then show 28 groups of value 1, followed by the groups 1, 1, 1, 3 of the byte 0xD5. Here a group value is {dib_hi, dib_lo}.
- R4: Each byte is sent as bits [1:0], [3:2], [5:4], [7:6] on successive clocks. In each group the lower-numbered bit is on dib_lo and the higher-numbered bit is on dib_hi. No clock is skipped between bytes.
- R5: s_ready is high for exactly one clock. This happens only while the last group of the delimiter, or of a data byte not flagged last, is on the pins. A byte taken at that edge shows its first group on the next clock.
- R6: s_ready stays low through the byte flagged last. dib_en falls on the clock after that byte's final group, so a frame of n bytes keeps dib_en high for 4*(8+n) clocks.
- R7: Between frames dib_en stays low for at least 48 clocks. If s_valid is already high when the gap ends, dib_en stays low for exactly 48 clocks.
- R8: If s_ready is high and s_valid is low at a clock edge, then on the next clock dib_en is 0, the pins are 00, and starved is high for exactly that one clock. The interframe gap follows.
- R9: s_byte and s_last have no effect on the pins at any edge where s_ready is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| s_byte | input | 8 | Frame byte from the source |
| s_valid | input | 1 | s_byte holds a frame byte |
| s_last | input | 1 | s_byte is the final byte of the frame |
| s_ready | output | 1 | Byte taken at this edge when s_valid is high |
| dib_lo | output | 1 | Earlier-sent bit of the current group |
| dib_hi | output | 1 | Later-sent bit of the current group |
| dib_en | output | 1 | Pins carry frame data |
| starved | output | 1 | One-clock pulse: source missed a byte mid-frame |

## Verification
The assertions assume that the source raises s_valid only at the start of a frame or to answer s_ready. They also assume that once a frame has begun, the source either keeps s_valid high until its last byte is taken or drops it on purpose to cause an underrun. The stimulus keeps to these rules. It holds s_valid high from the start of a frame until the byte flagged last has been accepted. It lowers s_valid early only in frames chosen to end in an underrun. While s_ready is low, it drives random values on s_byte and s_last, and it presents the real byte only during the clock in which s_ready is high.

// File: rtl/rmii_txs_pkg.sv
package rmii_txs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SFD,
    ST_DATA,
    ST_GAP
  } txs_state_e;

  typedef enum logic [1:0] {
    LD_PRE,
    LD_SFD,
    LD_DATA
  } txs_load_e;

endpackage

// File: rtl/rmii_txs_count.sv
module rmii_txs_count #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic         hit
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt + W'(1);
    end
  end

  assign hit = (cnt == limit);

endmodule

// File: rtl/rmii_txs_shifter.sv
module rmii_txs_shifter
  import rmii_txs_pkg::*;
#(
  parameter int          BYTE_W  = 8,
  parameter logic [7:0]  PRE_VAL = 8'h55,
  parameter logic [7:0]  SFD_VAL = 8'hD5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  txs_load_e         sel,
  input  logic              shift,
  input  logic              clr,
  input  logic [BYTE_W-1:0] s_byte,
  output logic              dib_lo,
  output logic              dib_hi
);

  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] ld_val;

  always_comb begin
    case (sel)
      LD_PRE:  ld_val = BYTE_W'(PRE_VAL);
      LD_SFD:  ld_val = BYTE_W'(SFD_VAL);
      default: ld_val = s_byte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      shreg <= '0;
    end else if (ld) begin
      shreg <= ld_val;
    end else if (shift) begin
      shreg <= {2'b00, shreg[BYTE_W-1:2]};
    end
  end

  assign dib_lo = shreg[0];
  assign dib_hi = shreg[1];

endmodule

// File: rtl/rmii_txs_ctrl.sv
module rmii_txs_ctrl
  import rmii_txs_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int PRE_BYTES = 7,
  parameter int GAP_CLKS  = 48
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      s_valid,
  input  logic      s_last,
  output logic      s_ready,
  output logic      dib_en,
  output logic      starved,
  output logic      ld,
  output txs_load_e sel,
  output logic      shift,
  output logic      clr
);

  localparam int DIBITS  = BYTE_W / 2;
  localparam int PH_W    = $clog2(DIBITS);
  localparam int CNT_MAX = (PRE_BYTES > GAP_CLKS) ? PRE_BYTES : GAP_CLKS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [PH_W-1:0] PH_END = PH_W'(DIBITS - 1);
  localparam logic [PH_W-1:0] PH_PRE = PH_W'(DIBITS - 2);
  localparam int LOW_W   = $clog2(GAP_CLKS + 1);

  txs_state_e      st, st_n;
  logic [PH_W-1:0] phase, ph_n;
  logic            act_n, rdy_n, starve_n, is_last, last_n;
  logic            cnt_clr, cnt_inc, cnt_hit;
  logic [CNT_W-1:0] cnt_lim;

  assign cnt_lim = (st == ST_PRE) ? CNT_W'(PRE_BYTES - 1) : CNT_W'(GAP_CLKS - 1);

  rmii_txs_count #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .limit (cnt_lim),
    .hit   (cnt_hit)
  );

  always_comb begin
    st_n     = st;
    ph_n     = phase;
    act_n    = dib_en;
    rdy_n    = 1'b0;
    starve_n = 1'b0;
    last_n   = is_last;
    ld       = 1'b0;
    sel      = LD_PRE;
    shift    = 1'b0;
    clr      = 1'b0;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    case (st)
      ST_IDLE: begin
        if (s_valid) begin
          st_n    = ST_PRE;
          ph_n    = '0;
          act_n   = 1'b1;
          ld      = 1'b1;
          cnt_clr = 1'b1;
        end
      end
      ST_GAP: begin
        if (cnt_hit) begin
          if (s_valid) begin
            st_n    = ST_PRE;
            ph_n    = '0;
            act_n   = 1'b1;
            ld      = 1'b1;
            cnt_clr = 1'b1;
          end else begin
            st_n = ST_IDLE;
          end
        end else begin
          cnt_inc = 1'b1;
        end
      end
      default: begin
        if (phase != PH_END) begin
          ph_n  = phase + PH_W'(1);
          shift = 1'b1;
          if (phase == PH_PRE) begin
            rdy_n = (st == ST_SFD) || ((st == ST_DATA) && !is_last);
          end
        end else begin
          ph_n = '0;
          if (st == ST_PRE) begin
            ld = 1'b1;
            if (cnt_hit) begin
              st_n = ST_SFD;
              sel  = LD_SFD;
            end else begin
              cnt_inc = 1'b1;
            end
          end else if ((st == ST_DATA) && is_last) begin
            act_n   = 1'b0;
            clr     = 1'b1;
            st_n    = ST_GAP;
            cnt_clr = 1'b1;
          end else if (s_valid) begin
            ld     = 1'b1;
            sel    = LD_DATA;
            last_n = s_last;
            st_n   = ST_DATA;
          end else begin
            act_n    = 1'b0;
            clr      = 1'b1;
            starve_n = 1'b1;
            st_n     = ST_GAP;
            cnt_clr  = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      phase   <= '0;
      dib_en  <= 1'b0;
      s_ready <= 1'b0;
      starved <= 1'b0;
      is_last <= 1'b0;
    end else begin
      st      <= st_n;
      phase   <= ph_n;
      dib_en  <= act_n;
      s_ready <= rdy_n;
      starved <= starve_n;
      is_last <= last_n;
    end
  end

  // Gap watch: low-run length since the line last went quiet.
  logic [LOW_W-1:0] low_cnt;
  logic             had_frame;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt   <= '0;
      had_frame <= 1'b0;
    end else begin
      had_frame <= had_frame | dib_en;
      if (dib_en) begin
        low_cnt <= '0;
      end else if (low_cnt != LOW_W'(GAP_CLKS)) begin
        low_cnt <= low_cnt + LOW_W'(1);
      end
    end
  end

  p_ready_last_dibit_r5: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> (dib_en && phase == PH_END));

  p_ready_single_r5: assert property (@(posedge clk) disable iff (rst)
    s_ready |=> !s_ready);

  p_last_no_ready_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DATA && is_last) |-> !s_ready);

  p_underrun_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    starved |-> (!dib_en && $past(s_ready) && !$past(s_valid)));

  p_gap_min_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(dib_en) && had_frame) |-> (low_cnt >= LOW_W'(GAP_CLKS)));

endmodule

// File: rtl/rmii_tx_serializer.sv
module rmii_tx_serializer
  import rmii_txs_pkg::*;
#(
  parameter int         BYTE_W    = 8,
  parameter int         PRE_BYTES = 7,
  parameter int         GAP_CLKS  = 48,
  parameter logic [7:0] PRE_VAL   = 8'h55,
  parameter logic [7:0] SFD_VAL   = 8'hD5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] s_byte,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  output logic              dib_lo,
  output logic              dib_hi,
  output logic              dib_en,
  output logic              starved
);

  logic      ld, shift, clr;
  txs_load_e sel;

  rmii_txs_ctrl #(
    .BYTE_W    (BYTE_W),
    .PRE_BYTES (PRE_BYTES),
    .GAP_CLKS  (GAP_CLKS)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .s_valid (s_valid),
    .s_last  (s_last),
    .s_ready (s_ready),
    .dib_en  (dib_en),
    .starved (starved),
    .ld      (ld),
    .sel     (sel),
    .shift   (shift),
    .clr     (clr)
  );

  rmii_txs_shifter #(
    .BYTE_W  (BYTE_W),
    .PRE_VAL (PRE_VAL),
    .SFD_VAL (SFD_VAL)
  ) u_shift (
    .clk    (clk),
    .rst    (rst),
    .ld     (ld),
    .sel    (sel),
    .shift  (shift),
    .clr    (clr),
    .s_byte (s_byte),
    .dib_lo (dib_lo),
    .dib_hi (dib_hi)
  );

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !dib_en |-> (!dib_lo && !dib_hi));

  p_preamble_start_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(dib_en) |-> ({dib_hi, dib_lo} == PRE_VAL[1:0]));

endmodule

// File: tb/rmii_tx_serializer_bench.sv
module rmii_tx_serializer_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] s_byte = 8'h00;
  logic       s_valid = 1'b0;
  logic       s_last = 1'b0;
  logic       s_ready, dib_lo, dib_hi, dib_en, starved;

  always #2 clk = ~clk;

  rmii_tx_serializer u_rmii_tx_serializer (
    .clk     (clk),
    .rst     (rst),
    .s_byte  (s_byte),
    .s_valid (s_valid),
    .s_last  (s_last),
    .s_ready (s_ready),
    .dib_lo  (dib_lo),
    .dib_hi  (dib_hi),
    .dib_en  (dib_en),
    .starved (starved)
  );

  int vectors = 0;
  int fails = 0;
  bit finished = 0;
  int cyc = 0;

  logic [7:0] fb [0:31];
  logic [1:0] cap [0:255];
  int cap_n = 0, rdy_cnt = 0, starve_cnt = 0, low_run = 0, last_gap = 0;
  int bad_idle = 0, bad_rdy = 0;
  bit prev_en = 0;
  int frames_done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_dibit(input int i);
    logic [7:0] b;
    if (i < 28) b = 8'h55;
    else if (i < 32) b = 8'hD5;
    else b = fb[(i - 32) / 4];
    return 2'((b >> (2 * (i % 4))) & 8'h03);
  endfunction

  // Monitor, sampling at the falling edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (dib_en) begin
        if (!prev_en) begin
          cap_n = 0;
          rdy_cnt = 0;
          last_gap = low_run;
        end
        if (cap_n < 256) cap[cap_n] = {dib_hi, dib_lo};
        cap_n++;
        low_run = 0;
      end else begin
        low_run++;
        if (dib_hi || dib_lo) bad_idle++;
      end
      if (s_ready) begin
        rdy_cnt++;
        if (!dib_en) bad_rdy++;
      end
      if (starved) starve_cnt++;
      prev_en = dib_en;
    end
  end

  task automatic send_frame(input int n, input int stall, input bit hold);
    int idx = 0;
    bit hs = 0;
    bit done = 0;
    int st0 = starve_cnt;
    int nacc, ndib, bad, first_bad;
    logic [1:0] fa, fe;
    s_valid = 1'b1;
    while (!done) begin
      @(negedge clk);
      if (hs) idx++;
      hs = 0;
      if (idx == n) begin
        s_valid = hold;
        s_last = 1'b0;
        done = 1;
      end else if (idx == stall && dib_en) begin
        s_valid = 1'b0;
        s_last = 1'b0;
        done = 1;
      end else if (s_ready) begin
        s_byte = fb[idx];
        s_last = (idx == n - 1);
        hs = 1;
      end else begin
        s_byte = 8'($urandom);
        s_last = 1'($urandom);
      end
    end
    do @(negedge clk); while (dib_en);
    @(posedge clk);
    #1;
    nacc = (stall < n) ? stall : n;
    ndib = 4 * (8 + nacc);
    chk(cap_n == ndib, "R6 dibit count", cap_n, ndib);
    bad = 0;
    first_bad = -1;
    fa = 0;
    fe = 0;
    for (int i = 0; i < ndib && i < 256; i++) begin
      if (cap[i] !== exp_dibit(i)) begin
        bad++;
        if (first_bad < 0) begin
          first_bad = i;
          fa = cap[i];
          fe = exp_dibit(i);
        end
      end
    end
    chk(bad == 0, "R3 R4 R9 dibit stream", int'(fa), int'(fe));
    chk(rdy_cnt == ((stall < n) ? stall + 1 : n), "R5 ready pulses", rdy_cnt,
        (stall < n) ? stall + 1 : n);
    chk(starve_cnt - st0 == ((stall < n) ? 1 : 0), "R8 underrun pulse",
        starve_cnt - st0, (stall < n) ? 1 : 0);
    if (frames_done > 0) chk(last_gap >= 48, "R7 gap", last_gap, 48);
    frames_done++;
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) fb[i] = 8'($urandom);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    chk(!dib_en && !s_ready && !starved && !dib_lo && !dib_hi, "R1 in reset",
        {dib_en, s_ready, starved, dib_hi, dib_lo}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!dib_en && !s_ready && !starved && !dib_lo && !dib_hi, "R1 after reset",
        {dib_en, s_ready, starved, dib_hi, dib_lo}, 0);

    // Directed: single byte frame, then back-to-back pair.
    fb[0] = 8'hE4;
    send_frame(1, 99, 1'b1);
    fb[0] = 8'h1B; fb[1] = 8'hC6;
    send_frame(2, 99, 1'b0);
    chk(last_gap == 48, "R7 exact gap with valid held", last_gap, 48);

    // Directed underruns: at the delimiter, and after three bytes.
    repeat (60) @(negedge clk);
    fill(8);
    send_frame(8, 0, 1'b0);
    repeat (60) @(negedge clk);
    fill(8);
    send_frame(8, 3, 1'b0);

    // Random frames.
    for (int f = 0; f < 14; f++) begin
      int n = 1 + int'($urandom % 20);
      int stall = (($urandom % 4) == 0) ? int'($urandom % n) : 99;
      fill(n);
      repeat (int'($urandom % 40)) @(negedge clk);
      send_frame(n, stall, 1'b0);
    end

    repeat (60) @(negedge clk);
    chk(bad_idle == 0, "R2 pins quiet while disabled", bad_idle, 0);
    chk(bad_rdy == 0, "R5 ready only while sending", bad_rdy, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule